// File: doc/BRIEF.md
# Oscillator Warm-Up Timer

This block times the settling interval of an oscillator that has just been restarted. Software picks a counting source (a fast or a slow reference, each delivered as a one-cycle enable strobe in the block's own clock domain), a prescale ratio of 1, 2, 4 or 8, and a warm-up length. It then issues a start request. The block counts prescaled source ticks until the count equals the programmed length. It then emits a single-cycle done pulse and stops.

Two byte-wide registers hold the settings. The control register carries the source select, the prescale code and a write-only clear-and-stop command. The length register holds the warm-up time. At each start request the block copies the source, prescale and length settings into working copies. Writes to the registers during a run therefore take effect only at the next start. A start request during a run restarts the run from zero. The clear-and-stop command halts the run at once and zeroes the count.

Top module: `wuc_timer`

## Requirements
- R1: After reset, the control register reads 0x07 (prescale code 01, slow source, fixed bit 0 set). The length register reads 0x00, and busy, done and count are all 0.
- R2: The control register sits at address 0 and the length register at address 1. Control bits 7..4 always read 0 and control bit 0 always reads 1. Control bit 1 (source) and bits 3..2 (prescale code) read back as written. The length register reads back as written.
- R3: Control bit 1 selects the counting source: 0 selects the fast strobe and 1 selects the slow strobe. The strobe that is not selected has no effect.
- R4: Prescale code 00, 01, 10 and 11 in control bits 3..2 makes one count tick per 1, 2, 4 and 8 selected strobes respectively.
- R5: Let the count reach the loaded length at clock edge E. Then done is high for exactly one cycle, after edge E+1. At that same edge busy falls, and count holds the length.
- R6: A length of 0 gives a done pulse after the second edge that follows the start request, with no tick needed.
- R7: Writing 1 to control bit 7 zeroes the count and clears busy at the next edge, and no done pulse follows. Bit 7 is not stored and reads 0. It takes priority over a start request in the same cycle.
- R8: A start request restarts the run: after the next edge busy is 1 and count is 0, even when a run was already in progress.
- R9: Writes to the control register during a run do not change that run's timing. The new settings apply from the next start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 control, 1 length |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 1 | Read address: 0 control, 1 length |
| rd_data | output | DATA_W | Read data (combinational) |
| start | input | 1 | Start or restart request, one cycle |
| fast_stb | input | 1 | Fast-source enable strobe |
| slow_stb | input | 1 | Slow-source enable strobe |
| busy | output | 1 | A warm-up run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| count | output | DATA_W | Current tick count |

## Verification
The bench builds the block with the default byte-wide registers. Short lengths of 0 to 6 therefore cover every prescale code and both sources within a few dozen cycles per run. The fast strobe fires every second cycle and the slow strobe every fifth, so a wrong source selection or a wrong prescale ratio shifts the done cycle in a way the bench detects. The bench predicts each done cycle by counting the strobes it delivers. It also covers a clear during a run, a restart during a run, and a settings change during a run.

// File: rtl/wuc_pkg.sv
// Package: shared register layout and helpers for the warm-up timer.
// Assumes a byte-wide register bus and a 2-bit prescale code.
package wuc_pkg;

    localparam int CODE_W   = 2;
    localparam int PRE_W    = 3;              // holds ratio-1 up to 7
    localparam int CLR_BIT  = 7;
    localparam int CODE_LSB = 2;
    localparam int SRC_BIT  = 1;

    // Working settings captured at each start request
    typedef struct packed {
        logic              src_slow;
        logic [CODE_W-1:0] div_code;
    } wuc_cfg_t;

    // Last prescaler value for a given code (ratio minus one)
    function automatic logic [PRE_W-1:0] div_last(input logic [CODE_W-1:0] code);
        logic [PRE_W:0] ratio;
        ratio = (PRE_W+1)'(1) << code;
        return PRE_W'(ratio - 1'b1);
    endfunction

endpackage

// File: rtl/wuc_regs.sv
// Module: control and length registers with fixed read-back bits.
// Assumes a single write port and a combinational read mux.
module wuc_regs
    import wuc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output wuc_cfg_t          cfg,
    output logic [DATA_W-1:0] wtime,
    output logic              clr_cmd
);

    logic [DATA_W-1:0] ctrl_view;

    // Store source select, prescale code and length
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg.src_slow <= 1'b1;
            cfg.div_code <= 2'b01;
            wtime        <= '0;
        end else if (wr_en) begin
            if (wr_addr == 1'b0) begin
                cfg.src_slow <= wr_data[SRC_BIT];
                cfg.div_code <= wr_data[CODE_LSB +: CODE_W];
            end else begin
                wtime <= wr_data;
            end
        end
    end

    // Clear-and-stop is a pulse, never stored
    always_comb clr_cmd = wr_en && (wr_addr == 1'b0) && wr_data[CLR_BIT];

    // Build the control view with fixed bits
    always_comb begin
        ctrl_view                        = '0;
        ctrl_view[0]                     = 1'b1;
        ctrl_view[SRC_BIT]               = cfg.src_slow;
        ctrl_view[CODE_LSB +: CODE_W]    = cfg.div_code;
    end

    // Read mux
    always_comb rd_data = rd_addr ? wtime : ctrl_view;

endmodule

// File: rtl/wuc_prescaler.sv
// Module: divides the selected source strobe by 1, 2, 4 or 8.
// Assumes restart has priority and the code is stable during a run.
module wuc_prescaler
    import wuc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              run,
    input  logic              stb,
    input  logic [CODE_W-1:0] code,
    output logic              tick
);

    logic [PRE_W-1:0] pre_q;
    logic             hit;

    // Detect the final strobe of a prescale period
    always_comb hit  = (pre_q == div_last(code));
    always_comb tick = run && stb && hit;

    // Advance the prescaler on each selected strobe
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            pre_q <= '0;
        end else if (run && stb) begin
            pre_q <= hit ? '0 : pre_q + 1'b1;
        end
    end

endmodule

// File: rtl/wuc_seq.sv
// Module: run control, working-setting capture and tick counter.
// Assumes clear has priority over start in the same cycle.
module wuc_seq
    import wuc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              clr,
    input  logic              tick,
    input  wuc_cfg_t          cfg,
    input  logic [DATA_W-1:0] wtime,
    output wuc_cfg_t          act_cfg,
    output logic              running,
    output logic              done,
    output logic [DATA_W-1:0] cnt
);

    logic [DATA_W-1:0] lim_q;

    // Sequence start, count, finish and clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_cfg <= '0;
            lim_q   <= '0;
            running <= 1'b0;
            done    <= 1'b0;
            cnt     <= '0;
        end else begin
            done <= 1'b0;
            if (clr) begin
                running <= 1'b0;
                cnt     <= '0;
            end else if (start) begin
                act_cfg <= cfg;
                lim_q   <= wtime;
                running <= 1'b1;
                cnt     <= '0;
            end else if (running) begin
                if (cnt == lim_q) begin
                    done    <= 1'b1;
                    running <= 1'b0;
                end else if (tick) begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/wuc_timer.sv
// Module: top of the oscillator warm-up timer.
// Assumes source strobes are synchronous one-cycle enables.
module wuc_timer
    import wuc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              start,
    input  logic              fast_stb,
    input  logic              slow_stb,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] count
);

    wuc_cfg_t          cfg;
    wuc_cfg_t          act_cfg;
    logic [DATA_W-1:0] wtime;
    logic              clr_cmd;
    logic              sel_stb;
    logic              tick;

    wuc_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .cfg(cfg), .wtime(wtime), .clr_cmd(clr_cmd)
    );

    // Pick the working source strobe
    always_comb sel_stb = act_cfg.src_slow ? slow_stb : fast_stb;

    wuc_prescaler u_pre (
        .clk(clk), .rst_n(rst_n), .restart(start || clr_cmd), .run(busy),
        .stb(sel_stb), .code(act_cfg.div_code), .tick(tick)
    );

    wuc_seq #(.DATA_W(DATA_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .clr(clr_cmd), .tick(tick),
        .cfg(cfg), .wtime(wtime), .act_cfg(act_cfg), .running(busy),
        .done(done), .cnt(count)
    );

endmodule

// File: rtl/wuc_timer_checker.sv
// Module: protocol checks for the warm-up timer, bound to the top.
module wuc_timer_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              rd_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic [DATA_W-1:0] count
);

    logic clr_req;
    always_comb clr_req = wr_en && !wr_addr && wr_data[7];

    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r7_clear_halts: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> (!busy && count == '0 && !done));

    a_r8_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !clr_req) |=> (busy && count == '0));

    a_r2_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_addr |-> (rd_data[7:4] == 4'h0 && rd_data[0]));

    a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$past(start))
            |-> (count == $past(count) || count == $past(count) + 1'b1));

endmodule

bind wuc_timer wuc_timer_checker #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .start(start), .busy(busy), .done(done), .count(count)
);

// File: tb/wuc_timer_test.sv
module wuc_timer_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_addr = 1'b0;
    logic [7:0] rd_data;
    logic       start = 1'b0;
    logic       fast_stb = 1'b0;
    logic       slow_stb = 1'b0;
    logic       busy, done;
    logic [7:0] count;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    wuc_timer #(.DATA_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .start(start), .fast_stb(fast_stb), .slow_stb(slow_stb),
        .busy(busy), .done(done), .count(count)
    );

    // vector: {src, code[1:0], length[7:0]}
    localparam logic [10:0] VEC [8] = '{
        {1'b0, 2'd0, 8'd3}, {1'b0, 2'd1, 8'd2}, {1'b0, 2'd2, 8'd2},
        {1'b0, 2'd3, 8'd1}, {1'b1, 2'd0, 8'd2}, {1'b1, 2'd1, 8'd3},
        {1'b1, 2'd3, 8'd1}, {1'b0, 2'd0, 8'd0}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One cycle: advance to the negedge and drive the strobe pattern
    task automatic step();
        @(negedge clk);
        cyc++;
        fast_stb = (cyc % 2 == 0);
        slow_stb = (cyc % 5 == 0);
    endtask

    task automatic do_write(input logic a, input logic [7:0] d);
        step();
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    // Start a run and compare the done cycle with the strobe-count model
    task automatic measure(input logic sel, input logic [1:0] code, input int lim,
                           input bit inject, input logic [7:0] inj_val, input string tag);
        int target, n, reached, obs;
        target  = lim * (1 << code);
        n       = 0;
        reached = (target == 0) ? 0 : -1;
        obs     = -1;
        step();
        start = 1'b1;
        for (int k = 1; k < 400; k++) begin
            step();
            start = 1'b0;
            wr_en = 1'b0;
            if (k == 1) chk(busy && count == 0, {tag, " R8 start zero"}, count, 0);
            if (done && obs < 0) begin
                obs = k;
                chk(count == lim, {tag, " R5 count holds"}, count, lim);
            end
            if (obs >= 0 && k == obs + 1) begin
                chk(!done && !busy, {tag, " R5 single pulse"}, done, 0);
                break;
            end
            if (inject && k == 3) begin
                wr_en = 1'b1; wr_addr = 1'b0; wr_data = inj_val;
            end
            if ((sel ? slow_stb : fast_stb) && reached < 0) begin
                n++;
                if (n == target) reached = k;
            end
        end
        chk(obs == reached + 2, {tag, " R3 R4 R5 R6 done cycle"}, obs, reached + 2);
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        step(); step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        do_read(1'b0, d); chk(d == 8'h07, "R1 ctrl reset", d, 8'h07);
        do_read(1'b1, d); chk(d == 8'h00, "R1 length reset", d, 0);
        chk(!busy && !done && count == 0, "R1 outputs reset", {busy, done}, 0);

        // R2 read-back with fixed bits
        do_write(1'b0, 8'hFF);
        do_read(1'b0, d); chk(d == 8'h0F, "R2 ctrl fixed bits", d, 8'h0F);
        do_write(1'b1, 8'hA5);
        do_read(1'b1, d); chk(d == 8'hA5, "R2 length readback", d, 8'hA5);

        // Table of source, prescale and length combinations
        foreach (VEC[i]) begin
            do_write(1'b0, {4'h0, VEC[i][9:8], VEC[i][10], 1'b0});
            do_write(1'b1, VEC[i][7:0]);
            measure(VEC[i][10], VEC[i][9:8], int'(VEC[i][7:0]), 1'b0, 8'h00,
                    $sformatf("vec%0d", i));
        end

        // R7 clear and stop during a run
        do_write(1'b0, 8'h00);
        do_write(1'b1, 8'd20);
        step(); start = 1'b1;
        step(); start = 1'b0;
        repeat (6) step();
        do_write(1'b0, 8'h80);
        chk(!busy && count == 0, "R7 clear halts", count, 0);
        begin
            bit seen = 0;
            for (int k = 0; k < 80; k++) begin
                step();
                if (done || busy) seen = 1;
            end
            chk(!seen, "R7 no done after clear", seen, 0);
        end
        do_read(1'b0, d); chk(d == 8'h01, "R7 clear bit not stored", d, 8'h01);

        // R7 clear wins over a same-cycle start
        do_write(1'b1, 8'd5);
        step(); start = 1'b1; wr_en = 1'b1; wr_addr = 1'b0; wr_data = 8'h80;
        step(); start = 1'b0; wr_en = 1'b0;
        chk(!busy && count == 0, "R7 clear beats start", busy, 0);

        // R8 restart during a run
        do_write(1'b1, 8'd6);
        step(); start = 1'b1;
        step(); start = 1'b0;
        repeat (5) step();
        chk(busy && count != 0, "R8 run in progress", count, 1);
        measure(1'b0, 2'd0, 6, 1'b0, 8'h00, "restart R8");

        // R9 settings change during a run is ignored
        do_write(1'b0, 8'h00);
        do_write(1'b1, 8'd4);
        measure(1'b0, 2'd0, 4, 1'b1, 8'h0E, "midrun R9");
        do_read(1'b0, d); chk(d == 8'h0F, "R9 new settings stored", d, 8'h0F);
        measure(1'b1, 2'd3, 4, 1'b0, 8'h00, "next start R9");

        finished = 1;
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule